// File: doc/BRIEF.md
# PCI Configuration Header Responder

This block answers configuration-space reads and writes for a single PCI function that uses a type-0 header. A request arrives in one cycle on a flat register port: a valid strobe, a write flag, a 12-bit byte offset, a size code and 32 bits of write data. Reads return their data one cycle later with a response strobe. Writes take effect at the clock edge that accepts them and produce no response.

The function holds a 16-bit command register and six base address register (BAR) slots. Slot 0 decodes a 1-byte I/O window and slot 1 decodes a 256-byte 32-bit memory window. Slots 2 to 5 are not implemented. The space-indicator bit of each BAR is fixed by hardware. A BAR that has been loaded with all ones answers with its size mask, which lets enumeration software learn the window size.

Identity values and capability offsets are parameters. The identity values are vendor, device, class and subclass. The header also carries a linked list of standard capabilities (power management, then PCI Express, then MSI-X) and a second list of extended capabilities (advanced error reporting, then virtual channel, then device serial number). Only the list headers are served. Any offset that is not decoded reads as zero.

Top module: `cfg_space_responder`

## Requirements
- R1: After reset, the command register and every BAR read as 0, and no response strobe is raised.
- R2: A read request raises `rspValid` for exactly one cycle, in the cycle after the request. A write request never raises it.
- R3: Identity offsets return fixed values:
  - offset 0x000 returns the vendor ID.
  - offset 0x002 returns the device ID.
  - offset 0x00E returns 0 (header type 0).
  - offset 0x00B returns the class code.
  - offset 0x00A returns only the subclass on a byte read, and (class code << 8) | subclass on a half-word or word read.
- R4: The size code selects how much of the 32-bit register value is returned, low-aligned, with the upper bits zero:
  - code 0 (byte) returns bits 7:0.
  - code 1 (half-word) returns bits 15:0.
  - codes 2 and 3 return the whole word.
- R5: A write to offset 0x004 loads the 16-bit command register from write-data bits 15:0. A word read at 0x004 returns the command value in bits 15:0 and zero above.
- R6: BAR0 sits at 0x010 and BAR1 at 0x014. On every write to them, bit 0 is forced to the BAR type: 1 for the I/O BAR0 and 0 for the memory BAR1.
- R7: If the BAR value produced by a write, before bit 0 is forced, is all ones, the BAR then reads as its size mask: 0xFFFFFFFD for BAR0 and 0xFFFFFF00 for BAR1. The next write that is not all ones returns the BAR to normal readback.
- R8: Writes are ignored at every offset except 0x004, 0x010 and 0x014. The unimplemented BAR slots at 0x018 to 0x024 always read 0.
- R9: The standard capability chain reads as follows (defaults PM 0x40, PCIe 0x50, MSI-X 0x90):
  - 0x034 returns the PM offset.
  - PM returns (PCIe offset << 8) | 0x01.
  - PCIe returns (MSI-X offset << 8) | 0x10.
  - MSI-X returns 0x11.
- R10: The extended capability chain reads as follows (defaults AER 0x100, VC 0x140, DSN 0x180):
  - AER returns (VC offset << 20) | 0x0001.
  - VC returns (DSN offset << 20) | 0x0002.
  - DSN returns 0x0003.
- R11: A read at any offset that is not decoded returns 0.
- R12: A byte write changes only bits 7:0 of the command register or BAR it hits, and a half-word write changes only bits 15:0. The rest of the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqOffset | input | 12 | Configuration byte offset |
| reqSize | input | 2 | 0 byte, 1 half-word, 2 or 3 word |
| reqWdata | input | 32 | Write data, low-aligned |
| rspValid | output | 1 | Read data valid |
| rspRdata | output | 32 | Read data, low-aligned |

## Verification
The checker assumes several things about the request port:
- `reqWrite`, `reqOffset` and `reqSize` are meaningful only while `reqValid` is high.
- At most one request arrives per cycle.
- The capability offsets keep their default values, because the checker's fixed expectations for the MSI-X header depend on them.

The bench keeps within these assumptions. It changes inputs only on the falling edge and drops `reqValid` between requests. It uses the defaults for every parameter and issues no request while reset is asserted. Its sizing stimulus reaches all ones by both a full-word write and a byte write that completes the pattern, so the all-ones detection is tested on the merged value.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

  localparam int NUM_BARS  = 6;
  localparam int IMPL_BARS = 2;
  localparam int BAR_IDX_W = $clog2(NUM_BARS);

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam logic [7:0]  CAP_ID_PM   = 8'h01;
  localparam logic [7:0]  CAP_ID_PCIE = 8'h10;
  localparam logic [7:0]  CAP_ID_MSIX = 8'h11;
  localparam logic [15:0] EXT_ID_AER  = 16'h0001;
  localparam logic [15:0] EXT_ID_VC   = 16'h0002;
  localparam logic [15:0] EXT_ID_DSN  = 16'h0003;

  typedef enum logic [3:0] {
    SEL_ZERO,
    SEL_VENDOR,
    SEL_DEVICE,
    SEL_CMD,
    SEL_CLASS,
    SEL_CLASSCODE,
    SEL_HDR,
    SEL_BAR,
    SEL_CAPPTR,
    SEL_PM,
    SEL_PCIE,
    SEL_MSIX,
    SEL_AER,
    SEL_VC,
    SEL_DSN
  } readSel_e;

  typedef struct packed {
    logic                 rdEn;
    logic                 cmdWe;
    logic [IMPL_BARS-1:0] barWe;
    readSel_e             sel;
    logic [BAR_IDX_W-1:0] barIdx;
    logic [1:0]           size;
  } ctrlStrobe_t;

  // Replace the low byte, the low half or the whole word of oldVal.
  function automatic logic [31:0] mergeLow(input logic [31:0] oldVal,
                                           input logic [31:0] newVal,
                                           input logic [1:0]  size);
    logic [31:0] res;
    case (size)
      SZ_BYTE: res = {oldVal[31:8], newVal[7:0]};
      SZ_HALF: res = {oldVal[31:16], newVal[15:0]};
      default: res = newVal;
    endcase
    return res;
  endfunction

  // Keep the low-aligned part of a register value that the size asks for.
  function automatic logic [31:0] fitSize(input logic [31:0] val,
                                          input logic [1:0]  size);
    logic [31:0] res;
    case (size)
      SZ_BYTE: res = {24'h0, val[7:0]};
      SZ_HALF: res = {16'h0, val[15:0]};
      default: res = val;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/cfg_space_ctrl.sv
module cfg_space_ctrl
  import cfg_space_pkg::*;
#(
  parameter logic [11:0] PM_OFF   = 12'h040,
  parameter logic [11:0] PCIE_OFF = 12'h050,
  parameter logic [11:0] MSIX_OFF = 12'h090,
  parameter logic [11:0] AER_OFF  = 12'h100,
  parameter logic [11:0] VC_OFF   = 12'h140,
  parameter logic [11:0] DSN_OFF  = 12'h180
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [11:0] reqOffset,
  input  logic [1:0]  reqSize,
  output ctrlStrobe_t strb,
  output logic        rspValid
);

  localparam logic [11:0] OFF_VENDOR    = 12'h000;
  localparam logic [11:0] OFF_DEVICE    = 12'h002;
  localparam logic [11:0] OFF_CMD       = 12'h004;
  localparam logic [11:0] OFF_CLASS     = 12'h00A;
  localparam logic [11:0] OFF_CLASSCODE = 12'h00B;
  localparam logic [11:0] OFF_HDR       = 12'h00E;
  localparam logic [11:0] OFF_BAR_BASE  = 12'h010;
  localparam logic [11:0] OFF_CAPPTR    = 12'h034;
  localparam logic [9:0]  BAR_DW_FIRST  = OFF_BAR_BASE[11:2];
  localparam logic [9:0]  BAR_DW_LAST   = BAR_DW_FIRST + 10'(NUM_BARS - 1);

  logic     isBar;
  logic [9:0] barDw;
  readSel_e sel;

  assign barDw = reqOffset[11:2] - BAR_DW_FIRST;
  assign isBar = (reqOffset[1:0] == 2'b00) &&
                 (reqOffset[11:2] >= BAR_DW_FIRST) &&
                 (reqOffset[11:2] <= BAR_DW_LAST);

  always_comb begin
    sel = SEL_ZERO;
    if (isBar)                           sel = SEL_BAR;
    else if (reqOffset == OFF_VENDOR)    sel = SEL_VENDOR;
    else if (reqOffset == OFF_DEVICE)    sel = SEL_DEVICE;
    else if (reqOffset == OFF_CMD)       sel = SEL_CMD;
    else if (reqOffset == OFF_CLASS)     sel = SEL_CLASS;
    else if (reqOffset == OFF_CLASSCODE) sel = SEL_CLASSCODE;
    else if (reqOffset == OFF_HDR)       sel = SEL_HDR;
    else if (reqOffset == OFF_CAPPTR)    sel = SEL_CAPPTR;
    else if (reqOffset == PM_OFF)        sel = SEL_PM;
    else if (reqOffset == PCIE_OFF)      sel = SEL_PCIE;
    else if (reqOffset == MSIX_OFF)      sel = SEL_MSIX;
    else if (reqOffset == AER_OFF)       sel = SEL_AER;
    else if (reqOffset == VC_OFF)        sel = SEL_VC;
    else if (reqOffset == DSN_OFF)       sel = SEL_DSN;
  end

  always_comb begin
    strb        = '0;
    strb.rdEn   = reqValid && !reqWrite;
    strb.cmdWe  = reqValid && reqWrite && (reqOffset == OFF_CMD);
    strb.sel    = sel;
    strb.barIdx = barDw[BAR_IDX_W-1:0];
    strb.size   = reqSize;
    for (int b = 0; b < IMPL_BARS; b++) begin
      strb.barWe[b] = reqValid && reqWrite && isBar &&
                      (barDw == 10'(b));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid && !reqWrite;
  end

endmodule

// File: rtl/cfg_space_datapath.sv
module cfg_space_datapath
  import cfg_space_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID    = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID    = 16'h5A17,
  parameter logic [7:0]  CLASS_CODE   = 8'h12,
  parameter logic [7:0]  SUBCLASS     = 8'h34,
  parameter int          IO_BAR_SIZE  = 1,
  parameter int          MEM_BAR_SIZE = 256,
  parameter logic [11:0] PM_OFF       = 12'h040,
  parameter logic [11:0] PCIE_OFF     = 12'h050,
  parameter logic [11:0] MSIX_OFF     = 12'h090,
  parameter logic [11:0] VC_OFF       = 12'h140,
  parameter logic [11:0] DSN_OFF      = 12'h180
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strb,
  input  logic [31:0] reqWdata,
  output logic [31:0] rspRdata
);

  logic [15:0] cmdQ;
  logic [31:0] cmdMerged;
  logic [31:0] barRead [NUM_BARS];
  logic [31:0] rdValue;

  assign cmdMerged = mergeLow({16'h0, cmdQ}, reqWdata, strb.size);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cmdQ <= '0;
    else if (strb.cmdWe) cmdQ <= cmdMerged[15:0];
  end

  for (genvar g = 0; g < NUM_BARS; g++) begin : gBar
    if (g < IMPL_BARS) begin : gImpl
      localparam logic        IS_IO     = (g == 0);
      localparam logic [31:0] WIN_SIZE  = IS_IO ? 32'(IO_BAR_SIZE) : 32'(MEM_BAR_SIZE);
      localparam logic [31:0] SIZE_MASK = IS_IO ?
                                          (((~(WIN_SIZE - 32'd1)) & 32'hFFFF_FFFC) | 32'd1) :
                                          ((~(WIN_SIZE - 32'd1)) & 32'hFFFF_FFF0);
      logic [31:0] barQ;
      logic        probeQ;
      logic [31:0] merged;

      assign merged = mergeLow(barQ, reqWdata, strb.size);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          barQ   <= '0;
          probeQ <= 1'b0;
        end else if (strb.barWe[g]) begin
          barQ   <= {merged[31:1], IS_IO};
          probeQ <= &merged;
        end
      end

      assign barRead[g] = probeQ ? SIZE_MASK : barQ;
    end else begin : gNone
      assign barRead[g] = '0;
    end
  end

  always_comb begin
    case (strb.sel)
      SEL_VENDOR:    rdValue = {16'h0, VENDOR_ID};
      SEL_DEVICE:    rdValue = {16'h0, DEVICE_ID};
      SEL_CMD:       rdValue = {16'h0, cmdQ};
      SEL_CLASS:     rdValue = (strb.size == SZ_BYTE) ? {24'h0, SUBCLASS} :
                                                        {16'h0, CLASS_CODE, SUBCLASS};
      SEL_CLASSCODE: rdValue = {24'h0, CLASS_CODE};
      SEL_HDR:       rdValue = '0;
      SEL_BAR:       rdValue = barRead[strb.barIdx];
      SEL_CAPPTR:    rdValue = {24'h0, PM_OFF[7:0]};
      SEL_PM:        rdValue = {16'h0, PCIE_OFF[7:0], CAP_ID_PM};
      SEL_PCIE:      rdValue = {16'h0, MSIX_OFF[7:0], CAP_ID_PCIE};
      SEL_MSIX:      rdValue = {24'h0, CAP_ID_MSIX};
      SEL_AER:       rdValue = {VC_OFF, 4'h0, EXT_ID_AER};
      SEL_VC:        rdValue = {DSN_OFF, 4'h0, EXT_ID_VC};
      SEL_DSN:       rdValue = {16'h0, EXT_ID_DSN};
      default:       rdValue = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rspRdata <= '0;
    else if (strb.rdEn) rspRdata <= fitSize(rdValue, strb.size);
  end

endmodule

// File: rtl/cfg_space_responder.sv
module cfg_space_responder
  import cfg_space_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID    = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID    = 16'h5A17,
  parameter logic [7:0]  CLASS_CODE   = 8'h12,
  parameter logic [7:0]  SUBCLASS     = 8'h34,
  parameter int          IO_BAR_SIZE  = 1,
  parameter int          MEM_BAR_SIZE = 256,
  parameter logic [11:0] PM_OFF       = 12'h040,
  parameter logic [11:0] PCIE_OFF     = 12'h050,
  parameter logic [11:0] MSIX_OFF     = 12'h090,
  parameter logic [11:0] AER_OFF      = 12'h100,
  parameter logic [11:0] VC_OFF       = 12'h140,
  parameter logic [11:0] DSN_OFF      = 12'h180
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [11:0] reqOffset,
  input  logic [1:0]  reqSize,
  input  logic [31:0] reqWdata,
  output logic        rspValid,
  output logic [31:0] rspRdata
);

  ctrlStrobe_t strb;

  cfg_space_ctrl #(
    .PM_OFF(PM_OFF), .PCIE_OFF(PCIE_OFF), .MSIX_OFF(MSIX_OFF),
    .AER_OFF(AER_OFF), .VC_OFF(VC_OFF), .DSN_OFF(DSN_OFF)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqOffset(reqOffset), .reqSize(reqSize), .strb(strb), .rspValid(rspValid)
  );

  cfg_space_datapath #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .CLASS_CODE(CLASS_CODE),
    .SUBCLASS(SUBCLASS), .IO_BAR_SIZE(IO_BAR_SIZE), .MEM_BAR_SIZE(MEM_BAR_SIZE),
    .PM_OFF(PM_OFF), .PCIE_OFF(PCIE_OFF), .MSIX_OFF(MSIX_OFF),
    .VC_OFF(VC_OFF), .DSN_OFF(DSN_OFF)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqWdata(reqWdata), .rspRdata(rspRdata)
  );

endmodule

// File: rtl/cfg_space_checker.sv
module cfg_space_checker #(
  parameter logic [15:0] VENDOR_ID = 16'hC0DE,
  parameter logic [11:0] MSIX_OFF  = 12'h090
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic [11:0] reqOffset,
  input logic [1:0]  reqSize,
  input logic        rspValid,
  input logic [31:0] rspRdata
);

  logic rdReq;
  logic bar0Seen;
  logic bar1Seen;

  assign rdReq = reqValid && !reqWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bar0Seen <= 1'b0;
      bar1Seen <= 1'b0;
    end else if (reqValid && reqWrite) begin
      if (reqOffset == 12'h010) bar0Seen <= 1'b1;
      if (reqOffset == 12'h014) bar1Seen <= 1'b1;
    end
  end

  assert_rsp_follows_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> rspValid);

  assert_no_rsp_without_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> !rspValid);

  assert_vendor_id_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && reqOffset == 12'h000 && reqSize == 2'd2) |=> (rspRdata == {16'h0, VENDOR_ID}));

  assert_byte_read_upper_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && reqSize == 2'd0) |=> (rspRdata[31:8] == 24'h0));

  assert_half_read_upper_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && reqSize == 2'd1) |=> (rspRdata[31:16] == 16'h0));

  assert_io_indicator_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && reqOffset == 12'h010 && bar0Seen) |=> rspRdata[0]);

  assert_mem_indicator_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && reqOffset == 12'h014 && bar1Seen) |=> !rspRdata[0]);

  assert_unimpl_bar_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && reqOffset >= 12'h018 && reqOffset <= 12'h027) |=> (rspRdata == 32'h0));

  assert_msix_tail_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && reqOffset == MSIX_OFF && reqSize == 2'd2) |=> (rspRdata == 32'h0000_0011));

  assert_undecoded_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && (reqOffset == 12'h03C || reqOffset == 12'h200)) |=> (rspRdata == 32'h0));

endmodule

bind cfg_space_responder cfg_space_checker #(
  .VENDOR_ID(VENDOR_ID), .MSIX_OFF(MSIX_OFF)
) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqOffset(reqOffset), .reqSize(reqSize), .rspValid(rspValid), .rspRdata(rspRdata)
);

// File: tb/tb_cfg_space_responder.sv
`timescale 1ns/1ps
module tb_cfg_space_responder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [11:0] reqOffset = '0;
  logic [1:0]  reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic [31:0] rspRdata;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_space_responder dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqOffset(reqOffset), .reqSize(reqSize), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] off;
    logic [1:0]  sz;
    logic [31:0] wd;
    logic [31:0] ex;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 52;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h004, 2'd2, 32'h0, 32'h0000_0000, 4'd1},      // R1 command after reset
    '{1'b0, 12'h010, 2'd2, 32'h0, 32'h0000_0000, 4'd1},      // R1 BAR0 after reset
    '{1'b0, 12'h014, 2'd2, 32'h0, 32'h0000_0000, 4'd1},      // R1 BAR1 after reset
    '{1'b0, 12'h000, 2'd2, 32'h0, 32'h0000_C0DE, 4'd3},      // R3 vendor
    '{1'b0, 12'h002, 2'd1, 32'h0, 32'h0000_5A17, 4'd3},      // R3 device
    '{1'b0, 12'h00E, 2'd0, 32'h0, 32'h0000_0000, 4'd3},      // R3 header type
    '{1'b0, 12'h00A, 2'd0, 32'h0, 32'h0000_0034, 4'd3},      // R3 class byte read
    '{1'b0, 12'h00A, 2'd2, 32'h0, 32'h0000_1234, 4'd3},      // R3 class word read
    '{1'b0, 12'h00B, 2'd0, 32'h0, 32'h0000_0012, 4'd3},      // R3 class code
    '{1'b0, 12'h000, 2'd0, 32'h0, 32'h0000_00DE, 4'd4},      // R4 byte of vendor
    '{1'b1, 12'h004, 2'd2, 32'hABCD_0147, 32'h0, 4'd5},      // R5 command write
    '{1'b0, 12'h004, 2'd2, 32'h0, 32'h0000_0147, 4'd5},      // R5 command readback
    '{1'b0, 12'h004, 2'd0, 32'h0, 32'h0000_0047, 4'd4},      // R4 byte of command
    '{1'b1, 12'h010, 2'd2, 32'h0000_1230, 32'h0, 4'd6},      // R6 BAR0 write
    '{1'b0, 12'h010, 2'd2, 32'h0, 32'h0000_1231, 4'd6},      // R6 I/O bit forced
    '{1'b1, 12'h014, 2'd2, 32'hFEDC_BA91, 32'h0, 4'd6},      // R6 BAR1 write
    '{1'b0, 12'h014, 2'd2, 32'h0, 32'hFEDC_BA90, 4'd6},      // R6 memory bit forced
    '{1'b1, 12'h010, 2'd2, 32'hFFFF_FFFF, 32'h0, 4'd7},      // R7 probe BAR0
    '{1'b0, 12'h010, 2'd2, 32'h0, 32'hFFFF_FFFD, 4'd7},      // R7 I/O mask
    '{1'b1, 12'h014, 2'd2, 32'hFFFF_FFFF, 32'h0, 4'd7},      // R7 probe BAR1
    '{1'b0, 12'h014, 2'd2, 32'h0, 32'hFFFF_FF00, 4'd7},      // R7 memory mask
    '{1'b0, 12'h014, 2'd1, 32'h0, 32'h0000_FF00, 4'd4},      // R4 half of mask
    '{1'b1, 12'h014, 2'd2, 32'h00A0_0000, 32'h0, 4'd7},      // R7 leave probe
    '{1'b0, 12'h014, 2'd2, 32'h0, 32'h00A0_0000, 4'd7},      // R7 normal again
    '{1'b0, 12'h010, 2'd2, 32'h0, 32'hFFFF_FFFD, 4'd7},      // R7 BAR0 still probed
    '{1'b1, 12'h000, 2'd2, 32'h1111_1111, 32'h0, 4'd8},      // R8 write to vendor
    '{1'b0, 12'h000, 2'd1, 32'h0, 32'h0000_C0DE, 4'd8},      // R8 vendor unchanged
    '{1'b1, 12'h018, 2'd2, 32'hFFFF_FFFF, 32'h0, 4'd8},      // R8 write BAR2
    '{1'b0, 12'h018, 2'd2, 32'h0, 32'h0000_0000, 4'd8},      // R8 BAR2 zero
    '{1'b1, 12'h040, 2'd2, 32'h0000_0000, 32'h0, 4'd8},      // R8 write cap header
    '{1'b0, 12'h040, 2'd2, 32'h0, 32'h0000_5001, 4'd9},      // R9 PM header
    '{1'b0, 12'h034, 2'd0, 32'h0, 32'h0000_0040, 4'd9},      // R9 cap pointer
    '{1'b0, 12'h050, 2'd2, 32'h0, 32'h0000_9010, 4'd9},      // R9 PCIe header
    '{1'b0, 12'h090, 2'd2, 32'h0, 32'h0000_0011, 4'd9},      // R9 MSI-X header
    '{1'b0, 12'h100, 2'd2, 32'h0, 32'h1400_0001, 4'd10},     // R10 AER
    '{1'b0, 12'h140, 2'd2, 32'h0, 32'h1800_0002, 4'd10},     // R10 VC
    '{1'b0, 12'h180, 2'd2, 32'h0, 32'h0000_0003, 4'd10},     // R10 DSN
    '{1'b0, 12'h03C, 2'd2, 32'h0, 32'h0000_0000, 4'd11},     // R11 undecoded
    '{1'b0, 12'h200, 2'd2, 32'h0, 32'h0000_0000, 4'd11},     // R11 undecoded
    '{1'b0, 12'h044, 2'd2, 32'h0, 32'h0000_0000, 4'd11},     // R11 inside PM body
    '{1'b1, 12'h010, 2'd0, 32'h0000_0055, 32'h0, 4'd12},     // R12 byte write BAR0
    '{1'b0, 12'h010, 2'd2, 32'h0, 32'hFFFF_FF55, 4'd12},     // R12 upper kept
    '{1'b1, 12'h014, 2'd1, 32'h0000_1234, 32'h0, 4'd12},     // R12 half write BAR1
    '{1'b0, 12'h014, 2'd2, 32'h0, 32'h00A0_1234, 4'd12},     // R12 upper kept
    '{1'b1, 12'h004, 2'd0, 32'h0000_00FF, 32'h0, 4'd12},     // R12 byte write command
    '{1'b0, 12'h004, 2'd2, 32'h0, 32'h0000_01FF, 4'd12},     // R12 high byte kept
    '{1'b1, 12'h010, 2'd0, 32'h0000_00FF, 32'h0, 4'd12},     // R12 byte completes ones
    '{1'b0, 12'h010, 2'd2, 32'h0, 32'hFFFF_FFFD, 4'd12},     // R12 merged probe
    '{1'b1, 12'h024, 2'd2, 32'h1234_5678, 32'h0, 4'd8},      // R8 write BAR5
    '{1'b0, 12'h024, 2'd2, 32'h0, 32'h0000_0000, 4'd8},      // R8 BAR5 zero
    '{1'b1, 12'h034, 2'd2, 32'h0000_00FF, 32'h0, 4'd8},      // R8 write cap pointer
    '{1'b0, 12'h034, 2'd2, 32'h0, 32'h0000_0040, 4'd8}       // R8 pointer unchanged
  };

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  task automatic doWrite(input logic [11:0] off, input logic [1:0] sz,
                         input logic [31:0] wd);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqOffset = off; reqSize = sz; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  // Returns data sampled on the falling edge after the accepting rising edge.
  task automatic doRead(input logic [11:0] off, input logic [1:0] sz,
                        output logic [31:0] data, output logic vld);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqOffset = off; reqSize = sz; reqWdata = '0;
    @(negedge clk);
    reqValid = 1'b0;
    data = rspRdata;
    vld  = rspValid;
  endtask

  initial begin
    logic [31:0] d;
    logic        v;
    repeat (3) @(negedge clk);
    check(1, "rspValid in reset", {31'h0, rspValid}, 32'h0);   // R1
    rstN = 1'b1;
    @(negedge clk);
    check(1, "rspValid after reset", {31'h0, rspValid}, 32'h0);  // R1

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) begin
        doWrite(VECS[i].off, VECS[i].sz, VECS[i].wd);
      end else begin
        doRead(VECS[i].off, VECS[i].sz, d, v);
        check(int'(VECS[i].req), $sformatf("vector %0d offset %03h", i, VECS[i].off),
              d, VECS[i].ex);
      end
    end

    // R2: a write raises no response; a read responds for a single cycle.
    doWrite(12'h004, 2'd2, 32'h0000_0002);
    check(2, "no response to write", {31'h0, rspValid}, 32'h0);
    doRead(12'h004, 2'd2, d, v);
    check(2, "response strobe", {31'h0, v}, 32'h1);
    check(5, "command after R2 write", d, 32'h0000_0002);
    @(negedge clk);
    check(2, "strobe drops", {31'h0, rspValid}, 32'h0);

    // R2: back-to-back reads, each answered in the following cycle.
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqOffset = 12'h000; reqSize = 2'd2;
    @(negedge clk);
    check(2, "b2b first strobe", {31'h0, rspValid}, 32'h1);
    check(3, "b2b first data", rspRdata, 32'h0000_C0DE);
    reqOffset = 12'h002;
    @(negedge clk);
    reqValid = 1'b0;
    check(2, "b2b second strobe", {31'h0, rspValid}, 32'h1);
    check(3, "b2b second data", rspRdata, 32'h0000_5A17);

    // R1: reset in the middle of operation clears command, BARs and probe state.
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    doRead(12'h004, 2'd2, d, v);
    check(1, "command after second reset", d, 32'h0);
    doRead(12'h010, 2'd2, d, v);
    check(1, "BAR0 after second reset", d, 32'h0);
    doRead(12'h014, 2'd2, d, v);
    check(1, "BAR1 after second reset", d, 32'h0);

    // R7: word probe straight after reset, then a plain value restores BAR0.
    doWrite(12'h010, 2'd2, 32'hFFFF_FFFF);
    doRead(12'h010, 2'd2, d, v);
    check(7, "BAR0 mask after reset", d, 32'hFFFF_FFFD);
    doWrite(12'h010, 2'd2, 32'h0000_0400);
    doRead(12'h010, 2'd2, d, v);
    check(7, "BAR0 normal after mask", d, 32'h0000_0401);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL R2 watchdog: actual %08h expected %08h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule